// File: doc/BRIEF.md
# Product-Term Cluster Steering Network

This block takes eighty product terms, grouped as sixteen clusters of five terms, and forms sixteen sum-of-products outputs, one per macrocell slot. Each cluster has one steering bit. When the bit is clear, the cluster's OR, together with whatever arrives from behind it, is delivered to the cluster's own slot. When the bit is set, that combined OR is passed on to the slot four positions ahead, and the cluster's own slot sees logic 0 from it.

The forwarding paths form four separate rings of four slots each. Slot n belongs to ring n mod 4, and the ring wraps from slot 12+c back to slot c. Because a slot accepts whatever is forwarded into it and may pass it on again, one slot can gather up to four clusters (twenty terms) into one wide sum. A ring in which all four members forward has nowhere to deliver its sums. The walk that gathers incoming terms stops after three steps back, so the ring is cut and no combinational loop forms. In that case all four slots of the ring read 0. The output is registered once, with a synchronous active-high reset.

Top module: `ptc_steer_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sop_out` is all zeros after that edge, whatever the inputs are.
- R2: Cluster n is product terms `pt_in[5n+4:5n]`. When `steer_cfg[n]` is 0, `sop_out[n]` is 1 if any of those five terms is 1.
- R3: When `steer_cfg[n]` is 1, `sop_out[n]` is 0. Nothing is delivered to that slot.
- R4: A cluster whose steer bit is 1 contributes to slot (n+4) mod 16. The wrap from slots 12 to 15 lands on slots 0 to 3.
- R5: Forwarded sums accumulate by OR over several hops. They land at the first slot along the ring whose steer bit is 0.
- R6: When all four steer bits of one ring are 1, all four outputs of that ring are 0, whatever the product terms are.
- R7: The rings are independent. The outputs of ring c depend only on the clusters and steer bits whose index is c mod 4.
- R8: `sop_out` reflects `pt_in` and `steer_cfg` as sampled at the previous rising edge, one cycle of latency, with a new result every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_in | input | 80 | Product terms; cluster n occupies bits 5n+4 down to 5n |
| steer_cfg | input | 16 | Per-cluster steer bit: 0 keeps the sum locally, 1 passes it four slots ahead |
| sop_out | output | 16 | Registered sum-of-products, one bit per slot |

## Verification
The hardest case to reach from the ports is a multi-hop path that wraps past slot 15, with the destination's own cluster quiet. In that case only the forwarded terms can light the destination. A ring where every member forwards is also hard to reach, because stray active terms elsewhere would mask a wrong result. The stimulus sets up these steer patterns on purpose, with a single active term in one cluster. It then runs the same patterns on other rings while the first ring stays local, to catch leakage between rings. Random vectors follow, with sparse terms so that individual hops remain visible at the outputs.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic {
        STEER_LOCAL = 1'b0,
        STEER_AHEAD = 1'b1
    } steer_e;

    // Flat slot index of ring member `pos` in ring `ring`
    function automatic int slot_of(input int ring, input int pos, input int n_rings);
        return pos * n_rings + ring;
    endfunction

    // Ring position that lies `back` steps behind `pos`, with wrap
    function automatic int pos_behind(input int pos, input int back, input int ring_len);
        return (pos - back + ring_len) % ring_len;
    endfunction

    // Bit mask selecting all slots of one ring (used by checks)
    function automatic logic [63:0] ring_mask(input int ring, input int n_rings, input int ring_len);
        logic [63:0] m;
        m = '0;
        for (int p = 0; p < ring_len; p++) begin
            m[p * n_rings + ring] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ptc_cluster_or.sv
module ptc_cluster_or #(
    parameter int TERMS   = 5,
    parameter int N_SLOTS = 16
) (
    input  logic [N_SLOTS*TERMS-1:0] pt_in,
    output logic [N_SLOTS-1:0]       cl_or
);
    for (genvar n = 0; n < N_SLOTS; n++) begin : g_cl
        assign cl_or[n] = |pt_in[n*TERMS +: TERMS];
    end
endmodule

// File: rtl/ptc_ring.sv
module ptc_ring
    import ptc_pkg::*;
#(
    parameter int RING_LEN = 4
) (
    input  logic [RING_LEN-1:0] cl_or,
    input  logic [RING_LEN-1:0] steer,
    output logic [RING_LEN-1:0] sum
);
    // Each position gathers from the members behind it, walking back at most
    // RING_LEN-1 steps. The walk never closes the ring, so an all-forward ring
    // has no combinational loop and every member's sum is gated to ground.
    always_comb begin
        for (int p = 0; p < RING_LEN; p++) begin
            logic acc;
            logic run;
            acc = 1'b0;
            run = 1'b1;
            for (int k = 1; k < RING_LEN; k++) begin
                run = run & (steer[pos_behind(p, k, RING_LEN)] == STEER_AHEAD);
                acc = acc | (run & cl_or[pos_behind(p, k, RING_LEN)]);
            end
            sum[p] = (steer[p] == STEER_LOCAL) & (cl_or[p] | acc);
        end
    end
endmodule

// File: rtl/ptc_steer_top.sv
module ptc_steer_top
    import ptc_pkg::*;
#(
    parameter int TERMS    = 5,
    parameter int N_RINGS  = 4,
    parameter int RING_LEN = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_RINGS*RING_LEN*TERMS-1:0]      pt_in,
    input  logic [N_RINGS*RING_LEN-1:0]            steer_cfg,
    output logic [N_RINGS*RING_LEN-1:0]            sop_out
);
    localparam int N_SLOTS = N_RINGS * RING_LEN;

    logic [N_SLOTS-1:0] cl_or;
    logic [N_SLOTS-1:0] sop_d;
    logic [N_SLOTS-1:0] sop_q;
    logic [RING_LEN-1:0] ring_cl    [N_RINGS];
    logic [RING_LEN-1:0] ring_steer [N_RINGS];
    logic [RING_LEN-1:0] ring_sum   [N_RINGS];

    ptc_cluster_or #(.TERMS(TERMS), .N_SLOTS(N_SLOTS)) u_cl (
        .pt_in (pt_in),
        .cl_or (cl_or)
    );

    for (genvar c = 0; c < N_RINGS; c++) begin : g_ring
        for (genvar p = 0; p < RING_LEN; p++) begin : g_pos
            localparam int S = p * N_RINGS + c;
            assign ring_cl[c][p]    = cl_or[S];
            assign ring_steer[c][p] = steer_cfg[S];
            assign sop_d[S]         = ring_sum[c][p];
        end

        ptc_ring #(.RING_LEN(RING_LEN)) u_ring (
            .cl_or (ring_cl[c]),
            .steer (ring_steer[c]),
            .sum   (ring_sum[c])
        );

        localparam logic [63:0] MASK64 = ring_mask(c, N_RINGS, RING_LEN);
        localparam logic [N_SLOTS-1:0] MASK = MASK64[N_SLOTS-1:0];

        AST_RING_CUT_GROUND: assert property (@(posedge clk) disable iff (rst)
            (&ring_steer[c]) |=> ((sop_out & MASK) == '0)); // R6
    end

    always_ff @(posedge clk) begin
        if (rst) sop_q <= '0;
        else     sop_q <= sop_d;
    end

    assign sop_out = sop_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sop_out == '0)); // R1

    for (genvar n = 0; n < N_SLOTS; n++) begin : g_chk
        localparam int NXT = (n + N_RINGS) % N_SLOTS;

        AST_LOCAL_HIT: assert property (@(posedge clk) disable iff (rst)
            (!steer_cfg[n] && cl_or[n]) |=> sop_out[n]); // R2

        AST_STEER_GROUND: assert property (@(posedge clk) disable iff (rst)
            steer_cfg[n] |=> !sop_out[n]); // R3

        AST_FWD_NEXT: assert property (@(posedge clk) disable iff (rst)
            (steer_cfg[n] && cl_or[n] && !steer_cfg[NXT]) |=> sop_out[NXT]); // R4
    end
endmodule

// File: tb/test_ptc_steer_top.sv
module test_ptc_steer_top;
    localparam int TERMS = 5;
    localparam int NS    = 16;
    localparam int NPT   = NS * TERMS;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NPT-1:0] pt_in = '0;
    logic [NS-1:0]  steer_cfg = '0;
    logic [NS-1:0]  sop_out;

    typedef struct {
        logic [NS-1:0] exp;
        string         tag;
    } item_t;

    item_t q[$];
    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    ptc_steer_top i_ptc_steer_top (
        .clk       (clk),
        .rst       (rst),
        .pt_in     (pt_in),
        .steer_cfg (steer_cfg),
        .sop_out   (sop_out)
    );

    // Forward-walk reference: follow each active cluster to its landing slot
    function automatic logic [NS-1:0] model(input logic [NPT-1:0] pt, input logic [NS-1:0] st);
        logic [NS-1:0] r;
        r = '0;
        for (int n = 0; n < NS; n++) begin
            int d;
            int hops;
            if (|pt[n*TERMS +: TERMS]) begin
                d = n;
                hops = 0;
                while (st[d] && hops < 4) begin
                    d = (d + 4) % NS;
                    hops++;
                end
                if (!st[d]) r[d] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic drive(input logic r, input logic [NPT-1:0] pt, input logic [NS-1:0] st, input string tag);
        item_t it;
        @(negedge clk);
        rst       = r;
        pt_in     = pt;
        steer_cfg = st;
        it.exp = r ? '0 : model(pt, st);
        it.tag = tag;
        q.push_back(it);
    endtask

    function automatic logic [NPT-1:0] one_term(input int cl, input int t);
        logic [NPT-1:0] v;
        v = '0;
        v[cl*TERMS + t] = 1'b1;
        return v;
    endfunction

    // Monitor: compare one item per cycle, 2 ns after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if (sop_out !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: sop_out=%h expected=%h", it.tag, sop_out, it.exp);
                end
            end
        end
    end

    initial begin
        logic [NPT-1:0] v;
        // R1: reset holds outputs at zero despite active inputs
        drive(1'b1, '1, '0, "R1");
        drive(1'b1, '1, 16'h00FF, "R1");
        // R2: all local, various single terms including last term of a cluster
        drive(1'b0, one_term(3, 4), '0, "R2");
        drive(1'b0, one_term(0, 0) | one_term(15, 2), '0, "R2");
        drive(1'b0, '1, '0, "R2");
        // R3/R4: one hop forward, source slot grounded
        drive(1'b0, one_term(2, 1), 16'h0004, "R3");
        drive(1'b0, one_term(2, 1) | one_term(6, 0), 16'h0004, "R4");
        // R4: wrap from slot 13 to slot 1
        drive(1'b0, one_term(13, 3), 16'h2000, "R4");
        // R5: multi-hop 0->4->8->12, destination own cluster quiet
        drive(1'b0, one_term(0, 2), 16'h0111, "R5");
        drive(1'b0, one_term(0, 2) | one_term(4, 4), 16'h0111, "R5");
        // R5: multi-hop with wrap 11->15->3, landing on slot 7
        drive(1'b0, one_term(11, 0), 16'h8808, "R5");
        // R6: whole ring 0 forwarding, all terms active
        drive(1'b0, '1, 16'h1111, "R6");
        drive(1'b0, '1, 16'hFFFF, "R6");
        // R7: ring 1 looped, ring 0 local; then ring 2 chained, others unaffected
        drive(1'b0, '1, 16'h2222, "R7");
        drive(1'b0, one_term(2, 0) | one_term(1, 1), 16'h0444, "R7");
        drive(1'b0, one_term(3, 3), 16'h0888, "R7");
        // R8: back-to-back random vectors, sparse terms
        for (int i = 0; i < 60; i++) begin
            v = '0;
            for (int j = 0; j < 6; j++) v[$urandom_range(NPT-1, 0)] = 1'b1;
            drive(1'b0, v, 16'($urandom), "R8");
        end
        // R1: reset mid-run clears
        drive(1'b1, '1, '0, "R1");
        drive(1'b0, one_term(5, 4), '0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: timeout actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule